// File: doc/BRIEF.md
# Three-Stage Instruction Pipeline with Fixed PC-Read Offset

This block is the front of a small in-order core. It fetches 32-bit fixed-width instruction words, decodes them in a second stage and executes them in a third. Each clock the fetch stage drives a byte address to an instruction memory. The memory answers with the word in the same cycle, because the block has no wait states. Addresses step by 4 bytes. So while the instruction at address X executes, decode holds X+4 and fetch is driving X+8.

An instruction that reads the program-counter register gets its own address plus 8. This value is part of the instruction encoding, not a sample of the fetch pointer, so it does not change if the pipeline depth changes. A taken jump resolves in execute. It redirects fetch and squashes the younger instructions by clearing their valid bits. The run-time input `delay_slot_en` chooses between two behaviours:
- Full flush: both younger instructions are discarded.
- Delay slot: the one instruction right after the jump still completes.

Completed instructions leave on a retire stream that carries a valid flag but no ready. The consumer must take one beat on any cycle, because the pipeline cannot be held. The instruction memory interface has no handshake for the same reason. A taken jump must not sit in the delay slot of another taken jump while delay-slot mode is on.

Top module: `pcofs_pipe`

## Requirements
- R1: While `rst` is high, `imem_addr` is 0 and `retire_valid` is 0. After `rst` falls, the word at address 0 retires on the second rising clock edge.
- R2: With no taken jump, fetch addresses step by 4 each cycle, and one instruction retires per clock in address order.
- R3: An instruction with opcode bits [31:28] = 4'h2 reads the PC. It retires with `retire_data` equal to its own address plus 8, zero-extended.
- R4: An instruction with opcode 4'h1 is a taken jump. Its target is bits [AW-1:0] with bits [1:0] forced to zero. It retires with `retire_data` equal to the target, and fetch continues at the target.
- R5: With `delay_slot_en` = 0, the two instructions after a taken jump never retire. The target retires exactly 3 cycles after the jump, and nothing retires in between.
- R6: With `delay_slot_en` = 1, the instruction at jump address + 4 retires the cycle after the jump. One empty cycle follows, then the target retires 3 cycles after the jump.
- R7: A jump whose target is the jump's own address + 4 still flushes and has the same timing as any other taken jump.
- R8: Opcode 4'h3 is a not-taken branch. It retires with `retire_data` equal to its decoded target, does not redirect fetch, and adds no empty cycle.
- R9: Any other opcode retires with `retire_data` equal to the instruction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| delay_slot_en | input | 1 | 1 keeps the instruction after a taken jump; 0 flushes both younger instructions |
| imem_addr | output | AW | Byte address of the word being fetched |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| retire_valid | output | 1 | An instruction completes this cycle |
| retire_addr | output | AW | Address of the completing instruction |
| retire_insn | output | 32 | Word of the completing instruction |
| retire_data | output | 32 | Result: PC read value, jump target, or the word itself |

## Verification
- **Directed program.** It puts a jump to the very next address ahead of a PC read. It also puts a PC read in a delay slot and a not-taken branch mid-stream. This separates a flush that is uniform from one that is skipped when the target matches the sequential path. It also shows whether the delay-slot instruction reads its own address + 8 or that of the jump.
- **Random programs.** They mix jumps, PC reads, not-taken branches and plain words. Each one runs under both flush settings and is compared cycle by cycle with an in-order model. A wrong bubble count, a missing or extra slot retirement, or a wrong PC-read offset each shows up as a mismatch in timing or in value.

// File: rtl/pcofs_pkg.sv
package pcofs_pkg;
  localparam int INSN_W      = 32;
  localparam int STEP        = 4;
  localparam int PC_READ_OFS = 8;

  localparam logic [3:0] OP_JUMP   = 4'h1;
  localparam logic [3:0] OP_RDPC   = 4'h2;
  localparam logic [3:0] OP_NOJUMP = 4'h3;

  typedef enum logic [1:0] {
    K_PLAIN  = 2'd0,
    K_JUMP   = 2'd1,
    K_RDPC   = 2'd2,
    K_NOJUMP = 2'd3
  } kind_e;

  function automatic kind_e decode_kind(input logic [3:0] op);
    case (op)
      OP_JUMP:   return K_JUMP;
      OP_RDPC:   return K_RDPC;
      OP_NOJUMP: return K_NOJUMP;
      default:   return K_PLAIN;
    endcase
  endfunction
endpackage

// File: rtl/pcofs_fetch.sv
module pcofs_fetch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_pc,
  output logic [AW-1:0] pc
);
  import pcofs_pkg::*;

  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  always_ff @(posedge clk) begin
    if (rst)           pc <= '0;
    else if (redirect) pc <= redirect_pc;
    else               pc <= pc + STEP_A;
  end

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> pc == $past(pc) + STEP_A);

  // R4
  redir_target_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> pc == $past(redirect_pc));
endmodule

// File: rtl/pcofs_decode.sv
module pcofs_decode #(
  parameter int AW = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic [AW-1:0]           f_pc,
  input  logic [pcofs_pkg::INSN_W-1:0] f_insn,
  output logic                    d_valid,
  output logic [AW-1:0]           d_pc,
  output logic [pcofs_pkg::INSN_W-1:0] d_insn,
  output pcofs_pkg::kind_e        d_kind,
  output logic [AW-1:0]           d_target
);
  import pcofs_pkg::*;

  // valid bit alone is cleared on flush; payload keeps loading
  always_ff @(posedge clk) begin
    if (rst || flush) d_valid <= 1'b0;
    else              d_valid <= 1'b1;
  end

  always_ff @(posedge clk) begin
    d_pc   <= f_pc;
    d_insn <= f_insn;
  end

  always_comb begin
    d_kind   = decode_kind(d_insn[INSN_W-1 -: 4]);
    d_target = {d_insn[AW-1:2], 2'b00};
  end

  // R5
  dec_flush_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !d_valid);

  // R1
  dec_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !d_valid);
endmodule

// File: rtl/pcofs_exec.sv
module pcofs_exec #(
  parameter int AW = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    delay_slot_en,
  input  logic                    d_valid,
  input  logic [AW-1:0]           d_pc,
  input  logic [pcofs_pkg::INSN_W-1:0] d_insn,
  input  pcofs_pkg::kind_e        d_kind,
  input  logic [AW-1:0]           d_target,
  output logic                    redirect,
  output logic [AW-1:0]           redirect_pc,
  output logic                    retire_valid,
  output logic [AW-1:0]           retire_addr,
  output logic [pcofs_pkg::INSN_W-1:0] retire_insn,
  output logic [pcofs_pkg::INSN_W-1:0] retire_data
);
  import pcofs_pkg::*;

  localparam int PADW = INSN_W - AW;
  localparam logic [AW-1:0] OFS_A = AW'(PC_READ_OFS);

  logic              e_valid;
  logic [AW-1:0]     e_pc;
  logic [INSN_W-1:0] e_insn;
  kind_e             e_kind;
  logic [AW-1:0]     e_target;
  logic [AW-1:0]     pc_read;

  always_ff @(posedge clk) begin
    if (rst)                            e_valid <= 1'b0;
    else if (redirect && !delay_slot_en) e_valid <= 1'b0;
    else                                e_valid <= d_valid;
  end

  always_ff @(posedge clk) begin
    e_pc     <= d_pc;
    e_insn   <= d_insn;
    e_kind   <= d_kind;
    e_target <= d_target;
  end

  always_comb begin
    redirect     = e_valid && (e_kind == K_JUMP);
    redirect_pc  = e_target;
    pc_read      = e_pc + OFS_A;
    retire_valid = e_valid;
    retire_addr  = e_pc;
    retire_insn  = e_insn;
    case (e_kind)
      K_RDPC:           retire_data = {{PADW{1'b0}}, pc_read};
      K_JUMP, K_NOJUMP: retire_data = {{PADW{1'b0}}, e_target};
      default:          retire_data = e_insn;
    endcase
  end

  // R5
  full_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (redirect && !delay_slot_en) |=> !e_valid);

  // R6
  slot_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (redirect && delay_slot_en) |=> e_valid == $past(d_valid));
endmodule

// File: rtl/pcofs_pipe.sv
module pcofs_pipe #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          delay_slot_en,
  output logic [AW-1:0] imem_addr,
  input  logic [31:0]   imem_rdata,
  output logic          retire_valid,
  output logic [AW-1:0] retire_addr,
  output logic [31:0]   retire_insn,
  output logic [31:0]   retire_data
);
  import pcofs_pkg::*;

  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  logic              redirect;
  logic [AW-1:0]     redirect_pc;
  logic              d_valid;
  logic [AW-1:0]     d_pc;
  logic [INSN_W-1:0] d_insn;
  kind_e             d_kind;
  logic [AW-1:0]     d_target;

  pcofs_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst(rst), .redirect(redirect),
    .redirect_pc(redirect_pc), .pc(imem_addr)
  );

  pcofs_decode #(.AW(AW)) u_decode (
    .clk(clk), .rst(rst), .flush(redirect),
    .f_pc(imem_addr), .f_insn(imem_rdata),
    .d_valid(d_valid), .d_pc(d_pc), .d_insn(d_insn),
    .d_kind(d_kind), .d_target(d_target)
  );

  pcofs_exec #(.AW(AW)) u_exec (
    .clk(clk), .rst(rst), .delay_slot_en(delay_slot_en),
    .d_valid(d_valid), .d_pc(d_pc), .d_insn(d_insn),
    .d_kind(d_kind), .d_target(d_target),
    .redirect(redirect), .redirect_pc(redirect_pc),
    .retire_valid(retire_valid), .retire_addr(retire_addr),
    .retire_insn(retire_insn), .retire_data(retire_data)
  );

  // R2
  retire_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && $past(retire_valid) && !$past(redirect))
      |-> retire_addr == $past(retire_addr) + STEP_A);
endmodule

// File: tb/pcofs_pipe_test.sv
module pcofs_pipe_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 16;
  localparam int CYC  = 300;
  localparam int MAXE = 512;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          delay_slot_en = 1'b0;
  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_rdata;
  logic          retire_valid;
  logic [AW-1:0] retire_addr;
  logic [31:0]   retire_insn;
  logic [31:0]   retire_data;

  logic [31:0] mem [0:63];
  assign imem_rdata = mem[imem_addr[7:2]];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcofs_pipe #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .delay_slot_en(delay_slot_en),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .retire_valid(retire_valid), .retire_addr(retire_addr),
    .retire_insn(retire_insn), .retire_data(retire_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [AW-1:0] exp_pc   [0:MAXE-1];
  logic [31:0]   exp_insn [0:MAXE-1];
  logic [31:0]   exp_data [0:MAXE-1];
  int            exp_cyc  [0:MAXE-1];
  string         exp_tag  [0:MAXE-1];
  int            n_exp;

  function automatic logic [31:0] data_of(input logic [AW-1:0] a, input logic [31:0] w);
    logic [AW-1:0] t;
    t = {w[AW-1:2], 2'b00};
    case (w[31:28])
      4'h1, 4'h3: return {16'h0, t};
      4'h2:       return {16'h0, a + 16'd8};
      default:    return w;
    endcase
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    case (w[31:28])
      4'h1:    return "R4";
      4'h2:    return "R3";
      4'h3:    return "R8";
      default: return "R2 R9";
    endcase
  endfunction

  function automatic void add_exp(input logic [AW-1:0] a, input int c, input string t);
    if (n_exp < MAXE) begin
      exp_pc[n_exp]   = a;
      exp_insn[n_exp] = mem[a[7:2]];
      exp_data[n_exp] = data_of(a, mem[a[7:2]]);
      exp_cyc[n_exp]  = c;
      exp_tag[n_exp]  = t;
      n_exp++;
    end
  endfunction

  // In-order reference: taken jump -> target 3 cycles later;
  // with delay slot, the next word retires 1 cycle after the jump.
  function automatic void build_model(input bit ds);
    logic [AW-1:0] pc;
    logic [31:0]   w;
    logic [AW-1:0] tgt;
    string         nxt;
    int            c;
    pc = '0; c = 2; n_exp = 0; nxt = "R1";
    while (c <= CYC && n_exp < MAXE - 2) begin
      w = mem[pc[7:2]];
      add_exp(pc, c, (nxt != "") ? nxt : tag_of(w));
      nxt = "";
      if (w[31:28] == 4'h1) begin
        tgt = {w[AW-1:2], 2'b00};
        if (ds) add_exp(pc + 16'd4, c + 1, "R6");
        nxt = (tgt == pc + 16'd4) ? "R7" : (ds ? "R6" : "R5");
        pc = tgt;
        c = c + 3;
      end else begin
        pc = pc + 16'd4;
        c = c + 1;
      end
    end
  endfunction

  task automatic load_directed();
    for (int i = 0; i < 64; i++) mem[i] = 32'h5000_0000 | i;
    mem[0]  = 32'h1000_0004;  // jump to next sequential address
    mem[1]  = 32'h2000_0000;  // PC read
    mem[2]  = 32'h3000_0040;  // not-taken branch
    mem[4]  = 32'h1000_0020;  // jump to 0x20
    mem[5]  = 32'h2000_0000;  // PC read in the slot
    mem[8]  = 32'h2000_0000;
    mem[10] = 32'h1000_0003;  // target low bits dropped -> 0x0
  endtask

  task automatic load_random();
    int r;
    for (int i = 0; i < 64; i++) begin
      r = int'($urandom % 10);
      if (r < 2)       mem[i] = {4'h1, 12'h0, 8'h0, 6'($urandom % 64), 2'($urandom)};
      else if (r < 4)  mem[i] = {4'h2, 28'($urandom)};
      else if (r == 4) mem[i] = {4'h3, 20'($urandom), 6'($urandom % 64), 2'b00};
      else             mem[i] = {4'(4 + ($urandom % 12)), 28'($urandom)};
    end
    for (int i = 0; i < 64; i++)
      if (mem[i][31:28] == 4'h1 && mem[(i + 1) % 64][31:28] == 4'h1)
        mem[(i + 1) % 64] = 32'h6000_0000 | i;
  endtask

  task automatic run(input bit ds);
    int  k;
    bit  here;
    bit  ok;
    build_model(ds);
    @(negedge clk);
    rst = 1'b1;
    delay_slot_en = ds;
    repeat (3) @(negedge clk);
    n_chk++;
    if (imem_addr !== '0 || retire_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: addr=%h valid=%b expected addr=0 valid=0", imem_addr, retire_valid);
    end
    rst = 1'b0;
    k = 0;
    for (int c = 1; c <= CYC; c++) begin
      @(negedge clk);
      here = (k < n_exp) && (exp_cyc[k] == c);
      if (retire_valid || here) begin
        n_chk++;
        ok = retire_valid && here && retire_addr == exp_pc[k] &&
             retire_insn == exp_insn[k] && retire_data == exp_data[k];
        if (!ok) begin
          n_bad++;
          if (here)
            $display("FAIL %s ds=%0d cyc=%0d: v=%b addr=%h insn=%h data=%h expected addr=%h insn=%h data=%h",
                     exp_tag[k], ds, c, retire_valid, retire_addr, retire_insn, retire_data,
                     exp_pc[k], exp_insn[k], exp_data[k]);
          else
            $display("FAIL R5/R6 ds=%0d cyc=%0d: retire addr=%h expected no retire", ds, c, retire_addr);
        end
        if (here) k++;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd24680));
    for (int i = 0; i < 64; i++) mem[i] = '0;
    load_directed();
    run(1'b0);
    run(1'b1);
    for (int p = 0; p < 4; p++) begin
      load_random();
      run(1'b0);
      run(1'b1);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule